// File: doc/BRIEF.md
# Pipelined Wallace Tree Multiplier

This block multiplies a wide unsigned multiplicand by a narrow unsigned multiplier and returns the full-width product. An AND array first turns every multiplier bit into one partial-product row, shifted to its bit weight. A tree of 3:2 carry-save adders then cuts the rows down to two vectors, a sum and a carry. The carry of each adder sits one bit higher than its sum. A carry-lookahead adder adds the last two vectors to give the product.

A register stage follows the operand input, the AND array, each carry-save level and the final adder. The pipeline never stalls, so the caller can present one operand pair on every clock. A valid flag travels with each operand pair, and the product appears a fixed number of cycles after the operands are sampled. Only the valid flags are reset. The data registers are not.

Top module: `wallace_mul_pipe`

## Requirements
- R1: When `prod_valid` is 1, `prod` holds the exact unsigned product `x_in * y_in` of the operand pair it belongs to, at the full width XW+YW (64 bits by default).
- R2: An operand pair sampled with `in_valid` = 1 at rising edge k gives `prod_valid` = 1 and its product right after rising edge k+6. In general the offset is LEVELS+2, where LEVELS is the number of carry-save levels (4 when YW = 8).
- R3: One operand pair is accepted on every rising edge with no stall. Back-to-back pairs leave the pipeline in the order they entered, one per cycle. At most LEVELS+3 pairs are in flight at any time.
- R4: A clock edge with `in_valid` = 0 gives no valid result for that slot, whatever the values of `x_in` and `y_in`.
- R5: The reset `rst` is synchronous and active high. It clears every valid flag. A pair sampled at or before the last edge with `rst` = 1 never gives a valid result, and `prod_valid` is 0 during reset.
- R6: Partial-product row i equals `x_in` shifted left by i when multiplier bit i is 1, and zero otherwise. Its low i bits and every bit at or above XW+i are therefore zero.
- R7: Each carry-save level keeps the sum of its rows, modulo 2^(XW+YW), unchanged from its input registers to its output registers. All rows after the last level, other than the first two, are zero.
- R8: The final lookahead adder stores the sum, modulo 2^(XW+YW), of the two vectors it received on the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand pair on `x_in`/`y_in` is to be multiplied |
| x_in | input | XW (56) | Unsigned multiplicand |
| y_in | input | YW (8) | Unsigned multiplier |
| prod_valid | output | 1 | `prod` holds a finished product |
| prod | output | XW+YW (64) | Unsigned product |

## Verification
Two events can fall on the same clock edge: a new operand pair entering the pipeline and a finished product leaving it. The reset edge can also land while pairs are in flight and a new pair is being offered. Continuous back-to-back streams, streams with bubbles, and a reset asserted with `in_valid` still high all provoke these collisions. At every falling edge the bench works out from its own launch log which result slot should be present. It treats a slot as void when the pair was sampled at or before the last reset edge. It then compares both the valid flag and the product, which it forms with an independent shift-and-add model.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

  // Rows left after one 3:2 level: each full group of three becomes two.
  function automatic int unsigned rows_after(input int unsigned n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Row count presented to reduction level lvl (level 0 sees n rows).
  function automatic int unsigned rows_at_level(input int unsigned n, input int unsigned lvl);
    int unsigned r;
    r = n;
    for (int unsigned k = 0; k < lvl; k++) r = rows_after(r);
    return r;
  endfunction

  // Number of carry-save levels needed to reach two rows.
  function automatic int unsigned tree_levels(input int unsigned n);
    int unsigned r;
    int unsigned k;
    r = n;
    k = 0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (r > 2) begin
        r = rows_after(r);
        k = k + 1;
      end
    end
    return k;
  endfunction

endpackage

// File: rtl/wtm_pp_array.sv
module wtm_pp_array #(
  parameter int XW = 56,
  parameter int YW = 8,
  localparam int PW = XW + YW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   v_in,
  input  logic [XW-1:0]          x,
  input  logic [YW-1:0]          y,
  output logic                   v_out,
  output logic [YW-1:0][PW-1:0]  rows
);

  function automatic logic [PW-1:0] pp_row(input logic [XW-1:0] xv, input logic b, input int sh);
    return b ? (PW'(xv) << sh) : '0;
  endfunction

  logic [YW-1:0][PW-1:0] rows_d;

  always_comb begin
    for (int i = 0; i < YW; i++) rows_d[i] = pp_row(x, y[i], i);
  end

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
    rows <= rows_d;
  end

  // R6: every registered row sits between its weight and weight+XW.
  for (genvar gi = 0; gi < YW; gi++) begin : g_chk
    logic [PW-1:0] row_low_mask;
    assign row_low_mask = (PW'(1) << gi) - PW'(1);
    assert_pp_align_R6: assert property (@(posedge clk) disable iff (rst)
      v_out |-> (((rows[gi] & row_low_mask) == '0) && ((rows[gi] >> (XW + gi)) == '0)));
  end

endmodule

// File: rtl/wtm_csa_level.sv
module wtm_csa_level #(
  parameter int W    = 64,
  parameter int ROWS = 8,
  parameter int NIN  = 8,
  localparam int NG    = NIN / 3,
  localparam int NLEFT = NIN % 3,
  localparam int NOUT  = NG * 2 + NLEFT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v_in,
  input  logic [ROWS-1:0][W-1:0] rows_in,
  output logic                  v_out,
  output logic [ROWS-1:0][W-1:0] rows_out
);

  function automatic logic [W-1:0] csa_sum(input logic [W-1:0] a, b, c);
    return a ^ b ^ c;
  endfunction

  // Majority bit moves up one weight.
  function automatic logic [W-1:0] csa_carry(input logic [W-1:0] a, b, c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

  function automatic logic [W-1:0] rows_total(input logic [ROWS-1:0][W-1:0] r);
    logic [W-1:0] t;
    t = '0;
    for (int i = 0; i < ROWS; i++) t = t + r[i];
    return t;
  endfunction

  logic [ROWS-1:0][W-1:0] rows_d;

  always_comb begin
    rows_d = '0;
    for (int g = 0; g < NG; g++) begin
      rows_d[2*g]   = csa_sum  (rows_in[3*g], rows_in[3*g+1], rows_in[3*g+2]);
      rows_d[2*g+1] = csa_carry(rows_in[3*g], rows_in[3*g+1], rows_in[3*g+2]);
    end
    for (int j = 0; j < NLEFT; j++) rows_d[2*NG+j] = rows_in[3*NG+j];
    // Idle rows (zero upstream) stay idle further down.
    for (int j = 0; j < ROWS - NIN; j++) rows_d[NOUT+j] = rows_in[NIN+j];
  end

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
    rows_out <= rows_d;
  end

  // R7: reduction leaves the arithmetic total of the rows unchanged.
  assert_level_total_R7: assert property (@(posedge clk) disable iff (rst)
    v_out |-> (rows_total(rows_out) == $past(rows_total(rows_in))));

endmodule

// File: rtl/wtm_cla.sv
module wtm_cla #(
  parameter int W = 64,
  localparam int NB = (W + 3) / 4,
  localparam int WP = NB * 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         v_out,
  output logic [W-1:0] s
);

  // Carries into bits 0..3 of a nibble plus its carry-out, each a flat
  // generate/propagate expression of the block carry-in.
  function automatic logic [4:0] nib_carries(input logic [3:0] g, p, input logic cin);
    logic [4:0] c;
    logic term;
    c[0] = cin;
    for (int j = 1; j <= 4; j++) begin
      c[j] = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = g[k];
        for (int m = k + 1; m < j; m++) term = term & p[m];
        c[j] = c[j] | term;
      end
      term = cin;
      for (int m = 0; m < j; m++) term = term & p[m];
      c[j] = c[j] | term;
    end
    return c;
  endfunction

  logic [WP-1:0] gen, prop, sum_d;

  always_comb begin
    logic       blk_c;
    logic [4:0] cs;
    gen   = WP'(a) & WP'(b);
    prop  = WP'(a) ^ WP'(b);
    blk_c = 1'b0;
    sum_d = '0;
    for (int nb = 0; nb < NB; nb++) begin
      cs = nib_carries(gen[4*nb +: 4], prop[4*nb +: 4], blk_c);
      sum_d[4*nb +: 4] = prop[4*nb +: 4] ^ cs[3:0];
      blk_c = cs[4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
    s <= sum_d[W-1:0];
  end

  // R8: stored result is the modular sum of last edge's operands.
  assert_cla_sum_R8: assert property (@(posedge clk) disable iff (rst)
    v_out |-> (s == W'($past(a) + $past(b))));

endmodule

// File: rtl/wallace_mul_pipe.sv
module wallace_mul_pipe #(
  parameter int XW = 56,
  parameter int YW = 8,
  localparam int PW     = XW + YW,
  localparam int LEVELS = wtm_pkg::tree_levels(YW),
  localparam int LAT    = LEVELS + 3,
  localparam int CW     = $clog2(LAT + 1) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  output logic          prod_valid,
  output logic [PW-1:0] prod
);

  // Operand register stage.
  logic          op_v;
  logic [XW-1:0] op_x;
  logic [YW-1:0] op_y;

  always_ff @(posedge clk) begin
    if (rst) op_v <= 1'b0;
    else     op_v <= in_valid;
    op_x <= x_in;
    op_y <= y_in;
  end

  // Row bundles between stages: index 0 is the AND-array output.
  logic [YW-1:0][PW-1:0] lvl_rows [LEVELS+1];
  logic [LEVELS:0]       lvl_v;

  wtm_pp_array #(.XW(XW), .YW(YW)) u_pp (
    .clk(clk), .rst(rst), .v_in(op_v), .x(op_x), .y(op_y),
    .v_out(lvl_v[0]), .rows(lvl_rows[0])
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    wtm_csa_level #(
      .W(PW), .ROWS(YW), .NIN(wtm_pkg::rows_at_level(YW, l))
    ) u_lvl (
      .clk(clk), .rst(rst), .v_in(lvl_v[l]), .rows_in(lvl_rows[l]),
      .v_out(lvl_v[l+1]), .rows_out(lvl_rows[l+1])
    );
  end

  wtm_cla #(.W(PW)) u_cla (
    .clk(clk), .rst(rst), .v_in(lvl_v[LEVELS]),
    .a(lvl_rows[LEVELS][0]), .b(lvl_rows[LEVELS][1]),
    .v_out(prod_valid), .s(prod)
  );

  // ---------------- checks ----------------
  // Rows past the final two must have been drained by the tree.
  logic tail_nonzero;
  always_comb begin
    tail_nonzero = 1'b0;
    for (int i = 2; i < YW; i++) tail_nonzero = tail_nonzero | (|lvl_rows[LEVELS][i]);
  end

  assert_tail_rows_zero_R7: assert property (@(posedge clk) disable iff (rst)
    lvl_v[LEVELS] |-> !tail_nonzero);

  // Occupancy counter: accepted minus delivered.
  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(in_valid) - CW'(prod_valid);
  end

  assert_inflight_bound_R3: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT));

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    prod_valid |-> (inflight != '0));

endmodule

// File: tb/wallace_mul_pipe_tb.sv
module wallace_mul_pipe_tb_top;

  localparam int XW = 56;
  localparam int YW = 8;
  localparam int PW = XW + YW;
  localparam int OFS = 6;     // result visible after edge k+OFS (R2)
  localparam int NV = 16;
  localparam int HIST = 4096;

  localparam logic [XW-1:0] VX [NV] = '{
    56'hFFFFFFFFFFFFFF, 56'hFFFFFFFFFFFFFF, 56'h00000000000000, 56'h00000000000001,
    56'h80000000000000, 56'h80000000000000, 56'h123456789ABCDE, 56'hAAAAAAAAAAAAAA,
    56'h55555555555555, 56'h0F0F0F0F0F0F0F, 56'hFFFFFFFFFFFFFF, 56'h00000000000003,
    56'hDEADBEEFCAFE12, 56'h7FFFFFFFFFFFFF, 56'h00FF00FF00FF00, 56'h31415926535897
  };
  localparam logic [YW-1:0] VY [NV] = '{
    8'hFF, 8'h01, 8'hFF, 8'hFF,
    8'h80, 8'hFF, 8'h5A, 8'h55,
    8'hAA, 8'hF0, 8'h00, 8'h80,
    8'h7F, 8'hFE, 8'h81, 8'hC3
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [XW-1:0] x_in = '0;
  logic [YW-1:0] y_in = '0;
  logic          prod_valid;
  logic [PW-1:0] prod;

  wallace_mul_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
    .prod_valid(prod_valid), .prod(prod)
  );

  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_rst = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string phase = "R5";
  bit            sent_v [HIST];
  logic [PW-1:0] sent_p [HIST];

  // Independent reference: shift-and-add over multiplier bits.
  function automatic logic [PW-1:0] ref_mul(input logic [XW-1:0] a, input logic [YW-1:0] b);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < YW; i++) if (b[i]) acc = acc + ({{YW{1'b0}}, a} << i);
    return acc;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) last_rst = cyc;
  end

  // Per-cycle scoreboard: valid flag and product of the slot due now.
  always @(negedge clk) begin
    if (chk_en && !done) begin
      int  l;
      bit  exp_v;
      l = cyc - OFS;
      exp_v = (l > last_rst) && (l >= 0) && (l < HIST) && sent_v[l];
      n_chk++;
      if (prod_valid !== exp_v) begin
        n_fail++;
        $display("FAIL %s valid slot %0d: got %0b expected %0b", phase, l, prod_valid, exp_v);
      end else if (exp_v && (prod !== sent_p[l])) begin
        // product check also covers R6, R7, R8 end to end
        n_fail++;
        $display("FAIL R1 product slot %0d: got %h expected %h", l, prod, sent_p[l]);
      end
    end
  end

  task automatic drive(input bit v, input logic [XW-1:0] a, input logic [YW-1:0] b);
    @(negedge clk);
    in_valid = v;
    x_in = a;
    y_in = b;
    if (cyc + 1 < HIST) begin
      sent_v[cyc+1] = v;
      sent_p[cyc+1] = ref_mul(a, b);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, {XW{1'b1}}, {YW{1'b1}});
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    report();
  end

  initial begin
    for (int i = 0; i < HIST; i++) begin
      sent_v[i] = 1'b0;
      sent_p[i] = '0;
    end
    chk_en = 1'b1;
    // R5: reset state, valid low while rst held even with in_valid high
    phase = "R5";
    for (int i = 0; i < 3; i++) drive(1'b1, 56'h1, 8'h1);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    idle(8);

    // R1/R2/R3: table vectors back to back
    phase = "R3";
    for (int i = 0; i < NV; i++) drive(1'b1, VX[i], VY[i]);
    idle(OFS + 2);

    // R2: isolated operation, measure edges to result
    phase = "R2";
    begin
      int launch;
      int seen;
      drive(1'b1, 56'h00000000000005, 8'h07);
      launch = cyc + 1;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      seen = -1;
      for (int i = 0; i < 20; i++) begin
        if (prod_valid && seen < 0) seen = cyc - launch;
        @(negedge clk);
      end
      n_chk++;
      if (seen != OFS) begin
        n_fail++;
        $display("FAIL R2 latency: got %0d expected %0d", seen, OFS);
      end
    end
    idle(4);

    // R3: random back-to-back stream
    phase = "R3";
    for (int i = 0; i < 300; i++) drive(1'b1, {$urandom, $urandom} , 8'($urandom));
    idle(OFS + 2);

    // R4: bubbles carrying garbage operands
    phase = "R4";
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 1) drive(1'b0, {$urandom, $urandom}, 8'($urandom));
      else            drive(1'b1, {$urandom, $urandom}, 8'($urandom));
    end
    idle(OFS + 2);

    // R5: reset mid-stream while new operands keep arriving
    phase = "R5";
    for (int i = 0; i < 4; i++) drive(1'b1, {XW{1'b1}}, {YW{1'b1}});
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    idle(OFS + 4);
    for (int i = 0; i < 3; i++) drive(1'b1, 56'h00000000000002 << i, 8'h03);
    idle(OFS + 3);

    done = 1'b1;
    report();
  end

endmodule